// File: doc/BRIEF.md
# Serial Flash Command Sequencer

The sequencer is the master-side engine that turns one flash request into the byte sequence an external serial NOR or page-buffered flash expects. A request is made of an operation (read, page program or sector erase), a 24-bit address, a byte count, a command family select, a slow-read mode bit and a cycle limit for write-enable confirmation. The sequencer drives chip select and hands each byte, one at a time, to a byte-exchange port that does the serial bit timing elsewhere. Program data enters through a ready/valid stream and read data leaves through another one.

For the two standard command families, program and erase start with a write-enable command in a frame of its own. Status frames are then repeated until the write-enable latch reads as set, and only then is the operation frame sent. The page-buffered family goes straight to the operation frame. A program burst never sends more than the family's write length, and the number of data bytes actually moved is reported when the request completes. Polling for completion of program or erase is done by a separate block.

Top module: `sflash_seq`

## Requirements
- R1: The operation frame sends the opcode first and then the 24-bit address as three bytes, bits 23:16, then 15:8, then 7:0, all inside one chip-select-low frame that is released after its last byte; each byte is held on `x_tx` with `x_req` high until `x_ack`.
- R2: A read (`op` = 2'b00) with `slow_read` = 0 uses opcode 0x0B and sends one 0x00 dummy byte after the address; with `slow_read` = 1 it uses 0x03 and no dummy byte. Each read data byte is exchanged by sending 0x00.
- R3: Opcodes by `family`: 0 gives program 0x02 and erase 0xD8; 1 gives program 0x02 and erase 0x20; 2 gives program 0x82 and erase 0x81; 3 behaves as 0. `op` = 2'b01 is program and `op` = 2'b1x is erase.
- R4: For families 0, 1 and 3, program and erase are preceded by a frame holding only 0x06, then by status frames {0x05, 0x00}, each in its own frame, repeated until bit 1 of the byte returned for the second status byte is 1.
- R5: For family 2, no write-enable frame and no status frame is sent.
- R6: A program sends min(`len`, write length) data bytes taken in order from the write stream, where the write length is 256 for families 0, 1, 3 and 264 for family 2; `sent_count` reports the bytes moved (the data bytes for a read, 0 for an erase).
- R7: Read data bytes appear on `rd_data` in exchange order, and while `rd_valid` is high and `rd_ready` low, `rd_valid` and `rd_data` hold.
- R8: If the write-enable latch is still clear when a status frame ends after `wel_limit` cycles of polling have elapsed, the request ends with `err` = 1, `sent_count` = 0 and no operation frame.
- R9: `done` is a one-cycle pulse in the first cycle chip select is high after the request; `err` and `sent_count` are valid from then on and `busy` is low on the next cycle.
- R10: After reset `busy` and `done` are 0, `cs_n` is 1 and `x_req` is 0; while idle the block keeps `cs_n` high and `x_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request strobe, taken while idle |
| op | input | 2 | Operation: 00 read, 01 program, 1x erase |
| family | input | 2 | Command family select |
| slow_read | input | 1 | 1 selects the read command without dummy byte |
| addr | input | 24 | Flash byte address |
| len | input | LEN_W | Requested byte count |
| wel_limit | input | LIM_W | Polling cycle limit for write-enable confirmation |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Write-enable confirmation timed out |
| sent_count | output | LEN_W | Data bytes moved by the last request |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Sequencer takes a program byte |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Consumer takes the read byte |
| cs_n | output | 1 | Flash chip select, active low |
| x_req | output | 1 | Byte exchange request |
| x_tx | output | 8 | Byte to send |
| x_ack | input | 1 | Byte exchange finished, `x_rx` valid |
| x_rx | input | 8 | Byte received during the exchange |

## Verification
A byte request follows in the cycle after the acknowledge of the byte before it, a new frame starts one chip-select-high cycle after the previous one ends, and `done` arrives in the cycle after the last acknowledge or the last accepted read byte. The bench drives every input and samples every output on the falling edge, so each value it logs is the one the next rising edge acts on. Its byte-exchange model acknowledges after a fixed wait and records each byte and each frame end, and its producer and consumer stall on fixed patterns. Results are compared with sequences built from the requirements once `done` has been seen, while per-cycle monitors catch chip select, phase and pulse-width violations as they happen.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WEN,
    ST_WGAP,
    ST_RCMD,
    ST_RDAT,
    ST_RCHK,
    ST_OPC,
    ST_ADR,
    ST_DUM,
    ST_WFETCH,
    ST_WBYTE,
    ST_RBYTE,
    ST_RPUSH,
    ST_FIN
  } seq_state_e;

  localparam logic [1:0] FAM_PAGED = 2'd2;
  localparam logic [1:0] FAM_STD_B = 2'd1;

  localparam logic [7:0] CMD_WEN      = 8'h06;
  localparam logic [7:0] CMD_STAT     = 8'h05;
  localparam logic [7:0] CMD_FILL     = 8'h00;
  localparam logic [7:0] CMD_RD_FAST  = 8'h0B;
  localparam logic [7:0] CMD_RD_SLOW  = 8'h03;
  localparam logic [7:0] CMD_PROG_STD = 8'h02;
  localparam logic [7:0] CMD_PROG_PG  = 8'h82;
  localparam logic [7:0] CMD_ERA_A    = 8'hD8;
  localparam logic [7:0] CMD_ERA_B    = 8'h20;
  localparam logic [7:0] CMD_ERA_PG   = 8'h81;

  typedef struct packed {
    logic [7:0] rd;
    logic [7:0] prog;
    logic [7:0] erase;
    logic       wen;
  } opset_t;

endpackage

// File: rtl/sfs_opsel.sv
module sfs_opsel
  import sfs_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int STD_WR_LEN = 256,
  parameter int PB_WR_LEN  = 264
) (
  input  logic [1:0]       family,
  input  logic             slow_read,
  output opset_t           ops,
  output logic [LEN_W-1:0] wr_len
);

  localparam logic [LEN_W-1:0] STD_LEN_V = LEN_W'(STD_WR_LEN);
  localparam logic [LEN_W-1:0] PB_LEN_V  = LEN_W'(PB_WR_LEN);

  always_comb begin
    ops.rd = slow_read ? CMD_RD_SLOW : CMD_RD_FAST;
    if (family == FAM_PAGED) begin
      ops.prog  = CMD_PROG_PG;
      ops.erase = CMD_ERA_PG;
      ops.wen   = 1'b0;
      wr_len    = PB_LEN_V;
    end else begin
      ops.prog  = CMD_PROG_STD;
      ops.erase = (family == FAM_STD_B) ? CMD_ERA_B : CMD_ERA_A;
      ops.wen   = 1'b1;
      wr_len    = STD_LEN_V;
    end
  end

endmodule

// File: rtl/sfs_poll_timer.sv
module sfs_poll_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q >= limit);

  always_comb begin
    cnt_en = clr || (en && !expired);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sfs_byte_ctr.sv
module sfs_byte_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfs_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int LIM_W      = 16,
  parameter int STD_WR_LEN = 256,
  parameter int PB_WR_LEN  = 264
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [1:0]       family,
  input  logic             slow_read,
  input  logic [23:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic [LIM_W-1:0] wel_limit,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [LEN_W-1:0] sent_count,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             cs_n,
  output logic             x_req,
  output logic [7:0]       x_tx,
  input  logic             x_ack,
  input  logic [7:0]       x_rx
);

  seq_state_e       state_q, state_d;
  logic [1:0]       op_q, fam_q;
  logic             slow_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [LIM_W-1:0] lim_q;
  logic [1:0]       idx_q;
  logic [7:0]       tx_q, rx_q;
  logic             err_q;

  logic             take;
  logic [1:0]       fam_eff;
  logic             slow_eff;
  opset_t           ops;
  logic [LEN_W-1:0] wr_len;
  logic             is_read, is_prog;
  logic [LEN_W-1:0] tgt;
  logic [LEN_W-1:0] cnt;
  logic             cnt_inc;
  logic             last_byte;
  logic             expired;
  logic             poll_en;
  logic [7:0]       main_opc;
  logic [7:0]       adr_byte;
  seq_state_e       data_entry;
  logic             idx_clr, idx_inc;
  logic             tx_en, rx_en;

  assign take     = (state_q == ST_IDLE) && start;
  assign fam_eff  = (state_q == ST_IDLE) ? family : fam_q;
  assign slow_eff = (state_q == ST_IDLE) ? slow_read : slow_q;

  sfs_opsel #(
    .LEN_W     (LEN_W),
    .STD_WR_LEN(STD_WR_LEN),
    .PB_WR_LEN (PB_WR_LEN)
  ) u_opsel (
    .family   (fam_eff),
    .slow_read(slow_eff),
    .ops      (ops),
    .wr_len   (wr_len)
  );

  assign is_read = (op_q == 2'b00);
  assign is_prog = (op_q == 2'b01);

  always_comb begin
    if (is_read)      tgt = len_q;
    else if (is_prog) tgt = (len_q < wr_len) ? len_q : wr_len;
    else              tgt = '0;
  end

  assign cnt_inc   = ((state_q == ST_WBYTE) && x_ack) ||
                     ((state_q == ST_RPUSH) && rd_ready);
  assign last_byte = ((cnt + 1'b1) == tgt);

  sfs_byte_ctr #(.W(LEN_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (take),
    .inc  (cnt_inc),
    .cnt  (cnt)
  );

  assign poll_en = (state_q == ST_RCMD) || (state_q == ST_RDAT) ||
                   (state_q == ST_RCHK);

  sfs_poll_timer #(.LIM_W(LIM_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_q == ST_WGAP),
    .en     (poll_en),
    .limit  (lim_q),
    .expired(expired)
  );

  always_comb begin
    if (is_read)      main_opc = ops.rd;
    else if (is_prog) main_opc = ops.prog;
    else              main_opc = ops.erase;
  end

  always_comb begin
    case (idx_q)
      2'd0:    adr_byte = addr_q[23:16];
      2'd1:    adr_byte = addr_q[15:8];
      default: adr_byte = addr_q[7:0];
    endcase
  end

  always_comb begin
    if (cnt == tgt)   data_entry = ST_FIN;
    else if (is_read) data_entry = ST_RBYTE;
    else              data_entry = ST_WFETCH;
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ((op == 2'b00) || !ops.wen) ? ST_OPC : ST_WEN;
      ST_WEN:    if (x_ack) state_d = ST_WGAP;
      ST_WGAP:   state_d = ST_RCMD;
      ST_RCMD:   if (x_ack) state_d = ST_RDAT;
      ST_RDAT:   if (x_ack) state_d = ST_RCHK;
      ST_RCHK: begin
        if (rx_q[1])      state_d = ST_OPC;
        else if (expired) state_d = ST_FIN;
        else              state_d = ST_RCMD;
      end
      ST_OPC:    if (x_ack) state_d = ST_ADR;
      ST_ADR: begin
        if (x_ack && (idx_q == 2'd2)) state_d = (is_read && !slow_q) ? ST_DUM : data_entry;
      end
      ST_DUM:    if (x_ack) state_d = data_entry;
      ST_WFETCH: if (wr_valid) state_d = ST_WBYTE;
      ST_WBYTE:  if (x_ack) state_d = last_byte ? ST_FIN : ST_WFETCH;
      ST_RBYTE:  if (x_ack) state_d = ST_RPUSH;
      ST_RPUSH:  if (rd_ready) state_d = last_byte ? ST_FIN : ST_RBYTE;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign idx_clr = (state_q == ST_OPC) && x_ack;
  assign idx_inc = (state_q == ST_ADR) && x_ack;
  assign tx_en   = (state_q == ST_WFETCH) && wr_valid;
  assign rx_en   = x_ack && ((state_q == ST_RDAT) || (state_q == ST_RBYTE));

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      fam_q  <= '0;
      slow_q <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      lim_q  <= '0;
    end else if (take) begin
      op_q   <= op;
      fam_q  <= family;
      slow_q <= slow_read;
      addr_q <= addr;
      len_q  <= len;
      lim_q  <= wel_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_clr || idx_inc) begin
      idx_q <= idx_clr ? 2'd0 : idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (tx_en) begin
      tx_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_en) begin
      rx_q <= x_rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (take || (state_q == ST_RCHK)) begin
      err_q <= !take && !rx_q[1] && expired;
    end
  end

  // outputs decoded from the state register
  always_comb begin
    case (state_q)
      ST_WEN:   x_tx = CMD_WEN;
      ST_RCMD:  x_tx = CMD_STAT;
      ST_OPC:   x_tx = main_opc;
      ST_ADR:   x_tx = adr_byte;
      ST_WBYTE: x_tx = tx_q;
      default:  x_tx = CMD_FILL;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_WEN, ST_RCMD, ST_RDAT, ST_OPC, ST_ADR, ST_DUM, ST_WBYTE, ST_RBYTE:
        x_req = 1'b1;
      default:
        x_req = 1'b0;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_WEN, ST_RCMD, ST_RDAT, ST_OPC, ST_ADR, ST_DUM,
      ST_WFETCH, ST_WBYTE, ST_RBYTE, ST_RPUSH:
        cs_n = 1'b0;
      default:
        cs_n = 1'b1;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign err        = err_q;
  assign sent_count = cnt;
  assign wr_ready   = (state_q == ST_WFETCH);
  assign rd_valid   = (state_q == ST_RPUSH);
  assign rd_data    = rx_q;

endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       x_req,
  input logic       x_ack,
  input logic [7:0] x_tx,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       wr_ready
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !x_req)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !x_req)); // R9

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R7

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && !x_ack) |=> (x_req && $stable(x_tx))); // R1

  AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    x_req |-> !cs_n); // R1

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!rd_valid && !x_req)); // R6

endmodule

bind sflash_seq sflash_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .cs_n    (cs_n),
  .x_req   (x_req),
  .x_ack   (x_ack),
  .x_tx    (x_tx),
  .rd_valid(rd_valid),
  .rd_ready(rd_ready),
  .rd_data (rd_data),
  .wr_ready(wr_ready)
);

// File: tb/test_sflash_seq.sv
`timescale 1ns/1ps
module test_sflash_seq;

  localparam int LEN_W = 16;
  localparam int LIM_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [1:0]       op, family;
  logic             slow_read;
  logic [23:0]      addr;
  logic [LEN_W-1:0] len;
  logic [LIM_W-1:0] wel_limit;
  logic             busy, done, err;
  logic [LEN_W-1:0] sent_count;
  logic [7:0]       wr_data;
  logic             wr_valid, wr_ready;
  logic [7:0]       rd_data;
  logic             rd_valid, rd_ready;
  logic             cs_n, x_req;
  logic [7:0]       x_tx;
  logic             x_ack;
  logic [7:0]       x_rx;

  always #2 clk = ~clk;

  sflash_seq i_sflash_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .family(family),
    .slow_read(slow_read), .addr(addr), .len(len), .wel_limit(wel_limit),
    .busy(busy), .done(done), .err(err), .sent_count(sent_count),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .cs_n(cs_n), .x_req(x_req), .x_tx(x_tx), .x_ack(x_ack), .x_rx(x_rx)
  );

  int n_chk = 0;
  int n_fail = 0;
  int got[$];
  int rdl[$];
  int exp_log[$];
  int exp_rd[$];
  int exp_cnt;
  int cyc = 0;
  int wait_c, fidx, first_b, polls_left, wdat, mon_bad, done_seen;
  int res_err, res_cnt;
  logic prev_cs;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural flash link, data producer and consumer, per-cycle monitors
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      x_ack = 1'b0; x_rx = 8'h00; wait_c = 2; fidx = 0; first_b = 0;
      prev_cs = 1'b1; wr_valid = 1'b0; wr_data = 8'h00; rd_ready = 1'b0;
    end else begin
      if (x_ack) begin
        x_ack = 1'b0;
      end else if (x_req) begin
        if (wait_c == 0) begin
          x_ack = 1'b1;
          wait_c = 2;
          got.push_back(int'(x_tx));
          if (fidx == 0) first_b = int'(x_tx);
          if (fidx == 1 && first_b == 8'h05) begin
            if (polls_left == 0) x_rx = 8'h02;
            else begin x_rx = 8'h01; polls_left--; end
          end else begin
            x_rx = 8'(8'h30 + fidx);
          end
          fidx++;
        end else begin
          wait_c--;
        end
      end
      if (cs_n && !prev_cs) begin got.push_back(-1); fidx = 0; end
      prev_cs = cs_n;
      wr_valid = (cyc % 3) != 0;
      wr_data = 8'(wdat);
      if (wr_valid && wr_ready) wdat++;
      rd_ready = (cyc % 4) != 1;
      if (rd_valid && rd_ready) rdl.push_back(int'(rd_data));
      if (done && !cs_n) mon_bad++;
      if (rd_valid && wr_ready) mon_bad++;
      if (x_req && cs_n) mon_bad++;
      if (done) begin done_seen++; res_err = int'(err); res_cnt = int'(sent_count); end
    end
  end

  task automatic build_expect(logic [1:0] o, logic [1:0] f, logic s, logic [23:0] a,
                              int n, int polls, int wbase);
    bit std = (f != 2'd2);
    int prog_c = std ? 8'h02 : 8'h82;
    int era_c = (f == 2'd2) ? 8'h81 : (f == 2'd1) ? 8'h20 : 8'hD8;
    int rd_c = s ? 8'h03 : 8'h0B;
    int hdr = 4;
    int m;
    exp_log.delete(); exp_rd.delete(); exp_cnt = 0;
    if (o != 2'b00 && std) begin
      exp_log.push_back(8'h06); exp_log.push_back(-1);
      for (int p = 0; p <= polls; p++) begin
        exp_log.push_back(8'h05); exp_log.push_back(8'h00); exp_log.push_back(-1);
      end
    end
    exp_log.push_back(o == 2'b00 ? rd_c : (o == 2'b01 ? prog_c : era_c));
    exp_log.push_back(int'(a[23:16]));
    exp_log.push_back(int'(a[15:8]));
    exp_log.push_back(int'(a[7:0]));
    if (o == 2'b00) begin
      if (!s) begin exp_log.push_back(0); hdr = 5; end
      for (int k = 0; k < n; k++) begin
        exp_log.push_back(0);
        exp_rd.push_back((8'h30 + hdr + k) & 255);
      end
      exp_cnt = n;
    end else if (o == 2'b01) begin
      m = std ? 256 : 264;
      if (n < m) m = n;
      for (int k = 0; k < m; k++) exp_log.push_back((wbase + k) & 255);
      exp_cnt = m;
    end
    exp_log.push_back(-1);
  endtask

  task automatic go(logic [1:0] o, logic [1:0] f, logic s, logic [23:0] a,
                    int n, int polls, int lim);
    int w = 0;
    got.delete(); rdl.delete();
    polls_left = polls; mon_bad = 0; done_seen = 0;
    op = o; family = f; slow_read = s; addr = a; len = LEN_W'(n);
    wel_limit = LIM_W'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_seen == 0 && w < 20000) begin @(negedge clk); w++; end
    check(w < 20000, "R9", "watchdog: done reached", w, 20000);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_log(string req);
    int bad = -1;
    if (got.size() == exp_log.size()) begin
      for (int i = 0; i < got.size(); i++)
        if (bad < 0 && got[i] != exp_log[i]) bad = i;
    end else bad = 0;
    check(bad < 0, req, "byte log mismatch (index,size)", bad < 0 ? got.size() : got[bad],
          bad < 0 ? exp_log.size() : exp_log[bad]);
  endtask

  task automatic run(string req, logic [1:0] o, logic [1:0] f, logic s,
                     logic [23:0] a, int n, int polls);
    int wb = wdat;
    build_expect(o, f, s, a, n, polls, wb);
    go(o, f, s, a, n, polls, 1000);
    cmp_log(req);
    check(res_cnt == exp_cnt, "R6", "sent_count", res_cnt, exp_cnt);
    check(res_err == 0, "R8", "err clear on success", res_err, 0);
    check(done_seen == 1 && mon_bad == 0, "R9", "single done pulse, clean frames",
          done_seen * 100 + mon_bad, 100);
    check(!busy && cs_n, "R10", "idle after request", int'(busy), 0);
    if (o == 2'b00) begin
      int bad = (rdl.size() == exp_rd.size()) ? -1 : 0;
      for (int i = 0; i < rdl.size() && bad < 0; i++) if (rdl[i] != exp_rd[i]) bad = i;
      check(bad < 0, "R7", "read stream order", rdl.size(), exp_rd.size());
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; family = '0; slow_read = 1'b0;
    addr = '0; len = '0; wel_limit = '0; wdat = 8'h50; polls_left = 0;
    repeat (5) @(negedge clk);
    check(cs_n == 1'b1, "R10", "cs_n in reset", int'(cs_n), 1);
    check(x_req == 1'b0, "R10", "x_req in reset", int'(x_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(done == 1'b0, "R10", "done after reset", int'(done), 0);

    run("R1 R2 fast read", 2'b00, 2'd0, 1'b0, 24'h123456, 5, 0);
    run("R2 slow read", 2'b00, 2'd1, 1'b1, 24'hABCDEF, 3, 0);
    run("R2 empty read", 2'b00, 2'd2, 1'b0, 24'h000102, 0, 0);
    run("R4 program fam0 with polls", 2'b01, 2'd0, 1'b0, 24'h010203, 4, 2);
    run("R6 program fam1 capped 256", 2'b01, 2'd1, 1'b0, 24'h00FF00, 300, 0);
    run("R3 erase fam0", 2'b10, 2'd0, 1'b0, 24'h040000, 0, 1);
    run("R3 erase fam1", 2'b11, 2'd1, 1'b0, 24'h002000, 0, 0);
    run("R3 erase fam3", 2'b10, 2'd3, 1'b0, 24'h070000, 0, 0);
    run("R5 program paged capped 264", 2'b01, 2'd2, 1'b0, 24'h000840, 300, 0);
    run("R5 erase paged", 2'b10, 2'd2, 1'b0, 24'h001080, 0, 0);

    // R8: latch never seen, limit 20 cycles
    go(2'b01, 2'd0, 1'b0, 24'h111111, 8, 100000, 20);
    check(res_err == 1, "R8", "err on timeout", res_err, 1);
    check(res_cnt == 0, "R8", "sent_count on timeout", res_cnt, 0);
    begin
      int opc_seen = 0;
      bit sof = 1'b1;
      foreach (got[i]) begin
        if (got[i] == -1) sof = 1'b1;
        else begin
          if (sof && got[i] != 8'h06 && got[i] != 8'h05) opc_seen++;
          sof = 1'b0;
        end
      end
      check(opc_seen == 0, "R8", "operation frames after timeout", opc_seen, 0);
      check(got.size() > 6, "R4", "status polled before timeout", got.size(), 7);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule